// File: doc/BRIEF.md
# Prescaled Multi-Channel Pulse-Width Modulator

This block drives up to four pulse-width modulated outputs. Each channel is set by one 32-bit control word, which is written and read through a small synchronous register port. The word holds four things: a run bit, a 13-bit clock prescaler, an 8-bit duty value and a bit that forces the output fully on. The prescaler divides the source clock by its value plus one. Each divided tick steps an 8-bit phase counter, so one output period is always 256 ticks long. The output is high while the phase is below the duty value.

Control words are spaced 16 bytes apart in the byte address space. Any accepted write to a channel takes effect at once: the current period is abandoned and a new one starts from phase zero. Clearing the run bit forces the output low straight away, without waiting for the period to end. The polarity is fixed: a high output means active.

Top module: `pwm_bank`

## Requirements
- R1: While and after a synchronous reset, every output is low and every control word reads back as zero.
- R2: Channel c's control word is at byte address 16*c. A read strobe returns that word on `rdata` after the next rising edge. Writes to addresses whose low 4 bits are not zero are ignored. Reads from such addresses return zero.
- R3: If a read and a write hit the same word in the same cycle, the read returns the value held before the write.
- R4: The prescaler is bits [12:0] (value S). The phase advances once every S+1 clocks, so S=0 advances it every clock. A write is sampled at edge E0. At edge E1+j the output reflects phase floor(j/(S+1)) mod 256.
- R5: The duty value is bits [23:16] (value D). With the channel running and bit 24 clear, the output is high exactly while the phase is below D, so D=0 keeps it low.
- R6: With bit 24 set and the channel running, the output stays high and bits [23:16] have no effect.
- R7: Bit 31 runs the channel. When a write clears it and is sampled at E0, the output is low from edge E1 onward.
- R8: Any accepted write to a running channel abandons the current period. Phase restarts at zero as in R4, including when the write lands on a prescaler tick.
- R9: A write to one channel leaves the timing and output of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 6 | Byte address; bits [5:4] pick the channel |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pwm_o | output | 4 | One PWM output per channel |

## Verification
Two events can fall in the same cycle: a control write reaching a channel, and that channel's own prescaler wrapping to advance the phase. The restart must win, so that the new period begins at phase zero and is not shifted by one tick. To provoke this, the bench rewrites a running channel at several cycle offsets, one of which lands exactly on a prescaler wrap. After each rewrite it compares the output with an arithmetic model that counts from the edge after the write. Read-during-write on one word is also driven in a single cycle and judged by the old value coming back.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int CTRL_W    = 32;
  localparam int PRE_W     = 13;
  localparam int DUTY_W    = 8;
  localparam int PRE_LSB   = 0;
  localparam int DUTY_LSB  = 16;
  localparam int FULL_BIT  = 24;
  localparam int RUN_BIT   = 31;
  localparam int STRIDE_LG = 4;
  typedef logic [CTRL_W-1:0] ctrl_word_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic                             rd_en,
  input  logic                             aligned,
  input  logic [IDX_W-1:0]                 idx,
  input  ctrl_word_t                       wdata,
  output ctrl_word_t                       rdata,
  output logic [NUM_CH-1:0]                run_o,
  output logic [NUM_CH-1:0]                full_o,
  output logic [NUM_CH-1:0]                load_o,
  output logic [NUM_CH-1:0][DUTY_W-1:0]    duty_o,
  output logic [NUM_CH-1:0][PRE_W-1:0]     scale_o
);
  ctrl_word_t [NUM_CH-1:0] words_q;
  logic hit;

  assign hit = aligned && (32'(idx) < NUM_CH);

  always_ff @(posedge clk) begin
    if (rst) begin
      words_q <= '0;
      load_o  <= '0;
      rdata   <= '0;
    end else begin
      if (wr_en && hit) words_q[idx] <= wdata;
      for (int c = 0; c < NUM_CH; c++)
        load_o[c] <= wr_en && hit && (32'(idx) == c);
      if (rd_en) rdata <= hit ? words_q[idx] : '0;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_fields
    assign run_o[c]   = words_q[c][RUN_BIT];
    assign full_o[c]  = words_q[c][FULL_BIT];
    assign duty_o[c]  = words_q[c][DUTY_LSB +: DUTY_W];
    assign scale_o[c] = words_q[c][PRE_LSB +: PRE_W];
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              run,
  input  logic              full,
  input  logic [DUTY_W-1:0] duty,
  input  logic [PRE_W-1:0]  scale,
  output logic              pwm_o
);
  logic [PRE_W-1:0]  pre_q, pre_n;
  logic [DUTY_W-1:0] phase_q, phase_n;
  logic              pwm_n;

  always_comb begin
    if (!run || load) begin
      pre_n   = '0;
      phase_n = '0;
    end else if (pre_q == scale) begin
      pre_n   = '0;
      phase_n = phase_q + 1'b1;
    end else begin
      pre_n   = pre_q + 1'b1;
      phase_n = phase_q;
    end
    pwm_n = run && (full || (phase_n < duty));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      phase_q <= '0;
      pwm_o   <= 1'b0;
    end else begin
      pre_q   <= pre_n;
      phase_q <= phase_n;
      pwm_o   <= pwm_n;
    end
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = IDX_W + STRIDE_LG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic [NUM_CH-1:0] pwm_o
);
  logic                          aligned;
  logic [IDX_W-1:0]              idx;
  logic [NUM_CH-1:0]             ch_run, ch_full, ch_load;
  logic [NUM_CH-1:0][DUTY_W-1:0] ch_duty;
  logic [NUM_CH-1:0][PRE_W-1:0]  ch_scale;

  assign aligned = (addr[STRIDE_LG-1:0] == '0);
  assign idx     = addr[ADDR_W-1:STRIDE_LG];

  pwm_bank_regs #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .aligned(aligned), .idx(idx), .wdata(wdata), .rdata(rdata),
    .run_o(ch_run), .full_o(ch_full), .load_o(ch_load),
    .duty_o(ch_duty), .scale_o(ch_scale)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_bank_chan chan_i (
      .clk(clk), .rst(rst), .load(ch_load[c]), .run(ch_run[c]),
      .full(ch_full[c]), .duty(ch_duty[c]), .scale(ch_scale[c]),
      .pwm_o(pwm_o[c])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_CH-1:0]             pwm_o,
  input logic [NUM_CH-1:0]             ch_run,
  input logic [NUM_CH-1:0]             ch_full,
  input logic [NUM_CH-1:0]             ch_load,
  input logic [NUM_CH-1:0][DUTY_W-1:0] ch_duty
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> (pwm_o == '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (rst)
      (ch_run[c] && !ch_full[c] && ch_duty[c] == '0) |=> !pwm_o[c]);
    assert_full_high_R6: assert property (@(posedge clk) disable iff (rst)
      (ch_run[c] && ch_full[c]) |=> pwm_o[c]);
    assert_stop_low_R7: assert property (@(posedge clk) disable iff (rst)
      !ch_run[c] |=> !pwm_o[c]);
    assert_restart_phase0_R8: assert property (@(posedge clk) disable iff (rst)
      (ch_load[c] && ch_run[c] && !ch_full[c]) |=> (pwm_o[c] == (ch_duty[c] != '0)));
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst(rst), .pwm_o(pwm_o), .ch_run(ch_run),
  .ch_full(ch_full), .ch_load(ch_load), .ch_duty(ch_duty)
);

// File: tb/pwm_bank_tb_top.sv
module pwm_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pwm_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;

  logic [31:0] cfg [4];
  int          start [4];
  bit          restarted [4];
  int          last_start = 0;

  pwm_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Arithmetic model of every output, compared on each falling edge.
  always @(negedge clk) begin
    if (!rst && mon_on) begin
      for (int c = 0; c < 4; c++) begin
        if (cyc >= start[c]) begin
          int j, s, ph;
          bit e;
          string tag;
          j  = cyc - start[c];
          s  = int'(cfg[c][12:0]);
          ph = (j / (s + 1)) % 256;
          e  = cfg[c][31] && (cfg[c][24] || (ph < int'(cfg[c][23:16])));
          if (!cfg[c][31])                          tag = "R7";
          else if (cfg[c][24])                      tag = "R6";
          else if (last_start > start[c])           tag = "R9";
          else if (restarted[c] && j <= 2*(s+1))    tag = "R8";
          else if (cfg[c][23:16] == 8'd0)           tag = "R5";
          else                                      tag = "R4 R5";
          check(pwm_o[c] === e, tag, 32'(pwm_o[c]), 32'(e));
        end
      end
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    addr = 6'(a); wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    if (a % 16 == 0) begin
      restarted[a/16] = cfg[a/16][31];
      cfg[a/16]       = d;
      start[a/16]     = cyc + 1;
      last_start      = cyc + 1;
    end
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = 6'(a); rd_en = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0;
    check(rdata === exp, tag, rdata, exp);
  endtask

  function automatic logic [31:0] word(bit run, bit full, int duty, int s);
    return {run, 6'b0, full, 8'(duty), 3'b0, 13'(s)};
  endfunction

  initial begin : watchdog
    #2000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int duties [7] = '{0, 1, 2, 127, 128, 254, 255};
    int k;
    for (int c = 0; c < 4; c++) begin
      cfg[c] = '0; start[c] = 0; restarted[c] = 1'b0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(pwm_o === 4'b0, "R1", 32'(pwm_o), 32'd0);
    rst = 1'b0;
    mon_on = 1'b1;
    for (int c = 0; c < 4; c++) rd(16*c, 32'd0, "R1");

    // R2: readback, stride, misaligned accesses
    for (int c = 0; c < 4; c++) wr(16*c, 32'h7E5A_1000 | 32'(c));
    for (int c = 3; c >= 0; c--) rd(16*c, 32'h7E5A_1000 | 32'(c), "R2");
    for (int c = 0; c < 4; c++) begin
      wr(16*c + 8, 32'hFFFF_FFFF);
      rd(16*c, 32'h7E5A_1000 | 32'(c), "R2");
      rd(16*c + 4, 32'd0, "R2");
    end

    // R3: read and write of the same word in one cycle
    @(negedge clk);
    addr = 6'd32; wdata = 32'h0033_0000; wr_en = 1'b1; rd_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
    restarted[2] = cfg[2][31]; cfg[2] = 32'h0033_0000;
    start[2] = cyc + 1; last_start = cyc + 1;
    check(rdata === 32'h7E5A_1002, "R3", rdata, 32'h7E5A_1002);
    rd(32, 32'h0033_0000, "R3");

    // R4 R5: duty sweep over small prescaler values, channels rotating
    k = 0;
    for (int s = 0; s < 3; s++) begin
      for (int d = 0; d < 7; d++) begin
        wr(16*(k % 4), word(1'b1, 1'b0, duties[d], s));
        k++;
        repeat (256*(s+1) + 4) @(posedge clk);
      end
    end
    for (int c = 0; c < 4; c++) wr(16*c, 32'd0);

    // R6: full duty with and without duty bits
    wr(0, word(1'b1, 1'b1, 0, 0));
    wr(16, word(1'b1, 1'b1, 64, 1));
    repeat (600) @(posedge clk);

    // R4: wider prescaler over two full periods, and the field maximum
    wr(0, word(1'b1, 1'b0, 3, 5));
    repeat (3100) @(posedge clk);
    wr(16, word(1'b1, 1'b0, 1, 8191));
    repeat (8192 + 40) @(posedge clk);
    wr(16, 32'd0);

    // R8: rewrites of a running channel, one landing on a prescaler wrap
    wr(0, word(1'b1, 1'b0, 128, 3));
    repeat (10) @(posedge clk);
    foreach (duties[d]) begin
      wr(0, word(1'b1, 1'b0, 128, 3));
      repeat (d + 2) @(posedge clk);
    end
    wr(0, word(1'b1, 1'b0, 2, 0));
    repeat (3) @(posedge clk);
    wr(0, word(1'b1, 1'b0, 200, 1));
    repeat (600) @(posedge clk);

    // R7: stop mid-period
    wr(32, word(1'b1, 1'b0, 200, 0));
    repeat (50) @(posedge clk);
    wr(32, word(1'b0, 1'b0, 200, 0));
    repeat (20) @(posedge clk);
    for (int c = 0; c < 4; c++) wr(16*c, 32'd0);
    repeat (5) @(posedge clk);

    @(negedge clk);
    mon_on = 1'b0;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule